// File: doc/BRIEF.md
# Programmable Down-Count Timer

This block is a general-purpose down-counting timer with a small byte-wide register interface. Software writes a reload value as a low byte and a high byte. A control byte sets run or pause, periodic or single-shot behaviour, the count source and the interrupt options. Each enabled count event lowers the counter by one. The count source is either a one-cycle internal tick or the rising edges of an external, asynchronous clock pin. When the last count of a period is consumed, the block sets an interrupt flag. The flag stays set until software reads the control register.

In periodic mode, the counter reloads at time-out and keeps running. In single-shot mode, the counter stops at time-out and the run bit in the control register clears itself. The next start then loads the full value again. Pausing keeps the remaining count, so a restart resumes from where the counter stopped. Writing a new reload byte while the timer is stopped makes the next start load that value. The interrupt can also be driven onto a general-purpose output pin, but only while that pin's select input is 0.

Top module: `gp_down_timer`

## Requirements
- R1: After reset, all four addresses read 0x00, and `irq_o` and `gpo0_o` are 0.
- R2: The register addresses are fixed:
  - Address 0 is control. Bit 0 is the interrupt enable, bit 1 is run, bit 2 is single-shot, bit 3 selects the external clock and bit 4 routes the interrupt to the pin.
  - Control bits 7:5 are not stored and always read as 0.
  - Address 1 holds the reload low byte and address 2 the reload high byte. Both read back what was written.
  - Address 3 reads 0.
- R3: While running from the internal tick, the time-out happens on the N-th tick. N is the reload value, and a reload value of 0 gives N = 65536. The interrupt flag is visible in the cycle after that tick.
- R4: In periodic mode (bit 2 = 0), the counter reloads at time-out. The next time-out follows after another N count events.
- R5: In single-shot mode (bit 2 = 1), the time-out clears the run bit and no further time-outs occur. Setting run again reloads the full value N.
- R6: Clearing the run bit holds the remaining count, and ticks while stopped have no effect. Setting run again, with no reload byte written in between, resumes from the held count.
- R7: With bit 3 = 1, each rising edge of `ext_clk_i` is one count event and `tick_i` is ignored. The edge passes through two synchronizing flops and takes effect on the third clock edge after it is sampled.
- R8: A time-out sets the interrupt flag whether or not bit 0 is set, and `irq_o` equals the flag AND bit 0. A read of address 0 clears the flag. A time-out in the same cycle as that read wins over the clear.
- R9: `gpo0_o` equals `irq_o` when bit 4 = 1 and `gpio_sel0_i` = 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational, 0 when no read) |
| tick_i | input | 1 | Internal count tick, one cycle per event |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| gpio_sel0_i | input | 1 | Select bit of general-purpose pin 0 (0 = timer may drive it) |
| irq_o | output | 1 | Timer interrupt |
| gpo0_o | output | 1 | Interrupt routed to general-purpose pin 0 |

## Verification
The assertions assume the following about the inputs:
- A read and a write never target the control register in the same cycle.
- Software does not start a single-shot timer in the very cycle it times out.
- `ext_clk_i` holds each level for at least two clocks, so that the synchronizer sees every edge.

The stimulus keeps within these rules:
- Every register access is a single-cycle strobe, issued only while `tick_i` is low.
- The external clock is driven with three-cycle high and low phases.
- Random reload values (1 to 40) and random modes are applied only while the counter is stopped.

// File: rtl/gp_tmr_pkg.sv
package gp_tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_RLD_LO = 2'd1,
    A_RLD_HI = 2'd2,
    A_NONE   = 2'd3
  } tmr_addr_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic route;
    logic ext_sel;
    logic one_shot;
    logic run;
    logic ien;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import gp_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic             os_done_i,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic             start_req_o,
  output logic             reload_wr_o,
  output logic             ctrl_rd_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  tmr_ctrl_t         ctrl_q;
  logic [BYTE_W-1:0] rld_lo_q;
  logic [HI_W-1:0]   rld_hi_q;
  tmr_addr_e         addr;
  tmr_ctrl_t         wctrl;

  assign addr  = tmr_addr_e'(addr_i);
  assign wctrl = tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr)
          A_CTRL:   ctrl_q   <= wctrl;
          A_RLD_LO: rld_lo_q <= wdata_i;
          A_RLD_HI: rld_hi_q <= wdata_i[HI_W-1:0];
          default: ;
        endcase
      end
      // single-shot completion overrides a concurrent write of the run bit
      if (os_done_i) ctrl_q.run <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign reload_o    = {rld_hi_q, rld_lo_q};
  assign start_req_o = wr_en_i && (addr == A_CTRL) && wctrl.run;
  assign reload_wr_o = wr_en_i && ((addr == A_RLD_LO) || (addr == A_RLD_HI));
  assign ctrl_rd_o   = rd_en_i && (addr == A_CTRL);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr)
        A_CTRL:   rdata_o = BYTE_W'(ctrl_q);
        A_RLD_LO: rdata_o = rld_lo_q;
        A_RLD_HI: rdata_o = BYTE_W'(rld_hi_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i[BYTE_W-1:CTRL_W];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             run_i,
  input  logic             one_shot_i,
  input  logic             start_req_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tc_o,
  output logic             os_done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             need_q;  // next start must load reload_i

  // a loaded 0 wraps through all ones, giving 2**CNT_W events
  assign tc_o      = run_i && ce_i && (cnt_q == LAST);
  assign os_done_o = tc_o && one_shot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      need_q <= 1'b1;
    end else begin
      if (tc_o) begin
        if (one_shot_i) begin
          cnt_q  <= '0;
          need_q <= 1'b1;
        end else begin
          cnt_q <= reload_i;
        end
      end else if (run_i && ce_i) begin
        cnt_q <= cnt_q - LAST;
      end else if (start_req_i && need_q) begin
        cnt_q  <= reload_i;
        need_q <= 1'b0;
      end
      if (reload_wr_i && !run_i) need_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  input  logic clr_i,
  input  logic ien_i,
  input  logic route_i,
  input  logic pin_sel_i,
  output logic irq_o,
  output logic pin_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (tc_i)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & ien_i;
  assign pin_o = irq_o & route_i & ~pin_sel_i;
endmodule

// File: rtl/gp_down_timer.sv
module gp_down_timer
  import gp_tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tick_i,
  input  logic       ext_clk_i,
  input  logic       gpio_sel0_i,
  output logic       irq_o,
  output logic       gpo0_o
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             start_req, reload_wr, ctrl_rd;
  logic             ext_rise, ce, tc, os_done;

  tmr_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .os_done_i   (os_done),
    .ctrl_o      (ctrl_q),
    .reload_o    (reload),
    .rdata_o,
    .start_req_o (start_req),
    .reload_wr_o (reload_wr),
    .ctrl_rd_o   (ctrl_rd)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk_i, .rst_ni,
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  assign ce = ctrl_q.ext_sel ? ext_rise : tick_i;

  tmr_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni,
    .ce_i        (ce),
    .run_i       (ctrl_q.run),
    .one_shot_i  (ctrl_q.one_shot),
    .start_req_i (start_req),
    .reload_wr_i (reload_wr),
    .reload_i    (reload),
    .tc_o        (tc),
    .os_done_o   (os_done),
    .cnt_o       (cnt)
  );

  tmr_irq i_irq (
    .clk_i, .rst_ni,
    .tc_i      (tc),
    .clr_i     (ctrl_rd),
    .ien_i     (ctrl_q.ien),
    .route_i   (ctrl_q.route),
    .pin_sel_i (gpio_sel0_i),
    .irq_o,
    .pin_o     (gpo0_o)
  );
endmodule

// File: rtl/gp_down_timer_chk.sv
module gp_down_timer_chk
  import gp_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [1:0]       addr_i,
  input logic [7:0]       rdata_o,
  input logic             irq_o,
  input logic             gpo0_o,
  input logic             gpio_sel0_i,
  input tmr_ctrl_t        ctrl_q,
  input logic             tc,
  input logic             ce,
  input logic             start_req,
  input logic             ext_rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0) |-> rdata_o[7:5] == 3'b000);  // R2

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && ce && !tc) |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));  // R3

  AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !ctrl_q.one_shot) |=> cnt == $past(reload));  // R4

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && ctrl_q.one_shot) |=> !ctrl_q.run);  // R5

  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !start_req) |=> $stable(cnt));  // R6

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise);  // R7

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0 && !tc) |=> !irq_o);  // R8

  AST_TC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && ctrl_q.ien) |=> (irq_o || !ctrl_q.ien));  // R8

  AST_PIN_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpo0_o |-> (irq_o && !gpio_sel0_i && ctrl_q.route));  // R9
endmodule

bind gp_down_timer gp_down_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .gpo0_o      (gpo0_o),
  .gpio_sel0_i (gpio_sel0_i),
  .ctrl_q      (ctrl_q),
  .tc          (tc),
  .ce          (ce),
  .start_req   (start_req),
  .ext_rise    (ext_rise),
  .cnt         (cnt),
  .reload      (reload)
);

// File: tb/test_gp_down_timer.sv
module test_gp_down_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tick_i = 1'b0, ext_clk_i = 1'b0, gpio_sel0_i = 1'b0;
  logic       irq_o, gpo0_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  gp_down_timer i_gp_down_timer (.*);

  function automatic logic [7:0] exp_ctrl(bit ien, bit run, bit os, bit ext, bit route);
    return {3'b000, route, ext, os, run, ien};
  endfunction

  function automatic int period_of(int rld);
    return (rld == 0) ? 65536 : rld;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic ext_pulse();
    ext_clk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic load(int rld);
    logic [7:0] d;
    wr(2'd0, 8'h00);
    wr(2'd1, rld[7:0]);
    wr(2'd2, rld[15:8]);
    rd(2'd0, d);  // drop any stale flag
  endtask

  task automatic run_tests();
    logic [7:0] d;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 irq after reset", irq_o, 1'b0);
    chk("R1 gpo after reset", gpo0_o, 1'b0);

    // R2 register map
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd(2'd1, d); chk("R2 reload lo", d, 8'hA5);
    rd(2'd2, d); chk("R2 reload hi", d, 8'h3C);
    wr(2'd0, 8'hE4);
    rd(2'd0, d); chk("R2 ctrl reserved bits", d, exp_ctrl(0, 0, 1, 0, 0));
    rd(2'd3, d); chk("R2 unused addr", d, 8'h00);

    // R3/R4/R5 random reloads and modes
    void'($urandom(32'h5EED_0001));
    for (int it = 0; it < 10; it++) begin
      int  n;
      bit  os;
      n  = 1 + int'($urandom % 40);
      os = bit'($urandom % 2);
      load(n);
      wr(2'd0, exp_ctrl(1, 1, os, 0, 0));
      ticks(period_of(n) - 1);
      chk("R3 no early time-out", irq_o, 1'b0);
      ticks(1);
      chk("R3 time-out on N-th tick", irq_o, 1'b1);
      rd(2'd0, d);
      chk(os ? "R5 run cleared" : "R4 run kept", d, exp_ctrl(1, !os, os, 0, 0));
      chk("R8 read clears", irq_o, 1'b0);
      ticks(period_of(n) - 1);
      chk(os ? "R5 no second time-out" : "R4 no early reload time-out", irq_o, 1'b0);
      ticks(1);
      chk(os ? "R5 stays stopped" : "R4 periodic time-out", irq_o, !os);
      rd(2'd0, d);
    end

    // R5 single-shot restart reloads full value
    load(3);
    wr(2'd0, exp_ctrl(1, 1, 1, 0, 0));
    ticks(3);
    chk("R5 one-shot fires", irq_o, 1'b1);
    rd(2'd0, d);
    ticks(10);
    chk("R5 idle after one-shot", irq_o, 1'b0);
    wr(2'd0, exp_ctrl(1, 1, 1, 0, 0));
    ticks(2);
    chk("R5 restart full period", irq_o, 1'b0);
    ticks(1);
    chk("R5 restart fires", irq_o, 1'b1);
    rd(2'd0, d);

    // R6 pause keeps count
    load(10);
    wr(2'd0, exp_ctrl(1, 1, 0, 0, 0));
    ticks(4);
    wr(2'd0, exp_ctrl(1, 0, 0, 0, 0));
    ticks(10);
    chk("R6 paused ignores ticks", irq_o, 1'b0);
    wr(2'd0, exp_ctrl(1, 1, 0, 0, 0));
    ticks(5);
    chk("R6 resume remaining", irq_o, 1'b0);
    ticks(1);
    chk("R6 resume fires", irq_o, 1'b1);
    rd(2'd0, d);

    // R7 external clock, tick ignored
    load(5);
    wr(2'd0, exp_ctrl(1, 1, 0, 1, 0));
    tick_i = 1'b1;
    repeat (4) ext_pulse();
    chk("R7 four edges, tick ignored", irq_o, 1'b0);
    ext_pulse();
    chk("R7 fifth edge time-out", irq_o, 1'b1);
    tick_i = 1'b0;
    rd(2'd0, d);

    // R8 flag set with interrupt disabled, R9 routing
    load(2);
    wr(2'd0, exp_ctrl(0, 1, 0, 0, 0));
    ticks(2);
    chk("R8 masked irq", irq_o, 1'b0);
    wr(2'd0, exp_ctrl(1, 1, 0, 0, 0));
    chk("R8 flag kept when masked", irq_o, 1'b1);
    gpio_sel0_i = 1'b1;
    wr(2'd0, exp_ctrl(1, 1, 0, 0, 1));
    chk("R9 pin select blocks", gpo0_o, 1'b0);
    gpio_sel0_i = 1'b0;
    #1 chk("R9 routed to pin", gpo0_o, 1'b1);
    @(negedge clk_i);
    rd(2'd0, d);
    chk("R9 pin clears with flag", gpo0_o, 1'b0);
    chk("R8 cleared", irq_o, 1'b0);

    // R3 reload of zero gives 65536 counts
    load(0);
    wr(2'd0, exp_ctrl(1, 1, 0, 0, 0));
    ticks(65535);
    chk("R3 zero reload no early", irq_o, 1'b0);
    ticks(1);
    chk("R3 zero reload 65536", irq_o, 1'b1);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog R3 actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule